// File: doc/BRIEF.md
# Triggered Probe Capture Buffer

This block is an on-chip logic analyzer core. On every rising edge of its sample clock it takes a snapshot of a bundle of probe signals and stores it in a circular memory. The newest sample replaces the oldest one. Capture continues until a trigger condition is met. The trigger is an AND of per-bit value conditions: each probe bit has a care bit and an expected value. After the trigger, the core stores a fixed number of further samples and then freezes the memory.

The trigger position controls how the frozen window is split around the trigger sample. The pre setting keeps mostly samples after the trigger. The center setting puts the trigger sample in the middle of the window. The post setting keeps mostly samples before the trigger. While the core is still filling its window after being armed, it ignores any trigger, so the part of the window before the trigger always holds real data.

A combinational read port returns the frozen samples in time order, oldest first. Status flags report whether capture is running, whether the trigger has fired and whether the window is complete. The sample clock drives the block's only clock pin, so it can never be one of the probe bits.

Top module: `probe_capture`

## Requirements
- R1: After a clock edge with `rst_n` low, `armed`, `triggered` and `done` are all 0.
- R2: A clock edge with `arm` high restarts capture. After that edge, `armed` = 1, `triggered` = 0 and `done` = 0. This holds even if a capture was already running. No sample is stored on an edge where `arm` is high.
- R3: While `armed` is 1 and `arm` is low, every clock edge stores `probe_in` as the newest sample. The buffer keeps the latest DEPTH samples, so each new sample overwrites the oldest.
- R4: A sample meets the trigger condition when `((probe_in ^ match_value) & care_mask) == 0`. Bits whose `care_mask` bit is 0 have no effect on the result.
- R5: A sample that meets the condition triggers only if at least DEPTH samples were stored since the last arm, not counting the sample itself. Earlier matches are ignored.
- R6: `trig_pos` selects the readout index T of the trigger sample, with DEPTH of at least 8:
  - 2'b00 (pre): T = DEPTH/8.
  - 2'b01 and 2'b11 (center): T = DEPTH/2.
  - 2'b10 (post): T = DEPTH-1-DEPTH/8.
- R7: The edge that stores the trigger sample sets `triggered`. Exactly DEPTH-1-T further samples are then stored. The edge that stores the last of them sets `done` = 1 and `armed` = 0. `triggered` stays 1 until the next arm.
- R8: Once `done` is 1, `rd_data` for `rd_idx` = i is the i-th oldest of the DEPTH retained samples, and index T holds the trigger sample.
- R9: While `done` is 1 and `arm` is low, changes on `probe_in` do not change anything that the read port returns.
- R10: Re-arming does not clear the buffer. Until the first sample after the arm is stored, the read port returns the same values it returned before the arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; probes are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start or restart capture |
| trig_pos | input | 2 | Trigger position: 00 pre, 01/11 center, 10 post |
| care_mask | input | PROBE_W | Per-bit enable of the trigger compare |
| match_value | input | PROBE_W | Per-bit expected value for the trigger |
| probe_in | input | PROBE_W | Probe signals to be sampled |
| rd_idx | input | $clog2(DEPTH) | Readout index, 0 = oldest retained sample |
| rd_data | output | PROBE_W | Sample at `rd_idx` |
| armed | output | 1 | Capture is running |
| triggered | output | 1 | Trigger has fired since the last arm |
| done | output | 1 | Window is frozen and readable |

## Verification
The bench builds the block with PROBE_W = 8 and DEPTH = 16. With these values, T is 2, 8 and 13 for the three positions, and a whole capture takes only a few dozen cycles. That is short enough to run every position, including the alternate center code, together with a match that comes before the fill ends, a masked near miss and an exact miss. A restart in the middle of a capture, a re-arm held high for a whole readout sweep, and probe activity after freezing are also within reach. The eight-bit probe width lets the test patterns separate matching upper nibbles from non-matching lower nibbles.

// File: rtl/cap_pkg.sv
// Shared types and helpers for the probe capture core.
// Assumes DEPTH is a power of two and at least 8.
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // never armed, or reset
        ST_FILL,   // armed, first DEPTH samples not yet stored
        ST_WAIT,   // armed, looking for the trigger
        ST_POST,   // triggered, storing the samples after the trigger
        ST_DONE    // window frozen
    } cap_state_t;

    localparam logic [1:0] POS_PRE  = 2'b00;
    localparam logic [1:0] POS_POST = 2'b10;

    // Readout index of the trigger sample for a given position code.
    function automatic int unsigned trig_slot(input logic [1:0] pos, input int unsigned depth);
        case (pos)
            POS_PRE:  return depth / 8;
            POS_POST: return depth - 1 - depth / 8;
            default:  return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/cap_match.sv
// Trigger comparator. A probe bit passes when its care bit is 0 or when
// it equals the expected value. The hit output is the AND of all bits.
// Purely combinational.
module cap_match #(
    parameter int PROBE_W = 8
) (
    input  logic [PROBE_W-1:0] sample,
    input  logic [PROBE_W-1:0] care,
    input  logic [PROBE_W-1:0] expect_val,
    output logic               hit
);
    logic [PROBE_W-1:0] bit_ok;

    for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
        // One bit passes if it is ignored or if it equals the expected value.
        assign bit_ok[b] = ~care[b] | (sample[b] ~^ expect_val[b]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/cap_buffer.sv
// Sample storage: one synchronous write port and one asynchronous read port.
// The contents are never cleared. Reset does not touch the memory.
module cap_buffer #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [PROBE_W-1:0] wdata,
    input  logic [AW-1:0]      raddr,
    output logic [PROBE_W-1:0] rdata
);
    logic [PROBE_W-1:0] mem [DEPTH];

    // Store one sample per enabled clock.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cap_ctrl.sv
// Capture sequencer. It runs the write pointer, waits for the fill,
// accepts one trigger, counts the samples after it and freezes.
// It also gives the readout base (oldest retained address), derived
// from the stored trigger address. Assumes DEPTH is a power of two
// and at least 8.
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          hit,
    input  logic [1:0]    pos,
    output logic          we,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_base,
    output logic          armed,
    output logic          triggered,
    output logic          done
);
    cap_state_t    state;
    logic [AW-1:0] trig_addr;
    logic [AW-1:0] trig_idx;
    logic [AW-1:0] remain;
    logic [AW-1:0] new_idx;

    // Trigger slot for the position code on the inputs now.
    always_comb new_idx = AW'(trig_slot(pos, DEPTH));

    assign armed     = (state == ST_FILL) || (state == ST_WAIT) || (state == ST_POST);
    assign triggered = (state == ST_POST) || (state == ST_DONE);
    assign done      = (state == ST_DONE);
    assign we        = armed && !arm;
    assign rd_base   = trig_addr - trig_idx;

    // Sequencer state, write pointer and the stored trigger data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_ptr    <= '0;
            trig_addr <= '0;
            trig_idx  <= '0;
            remain    <= '0;
        end else if (arm) begin
            state  <= ST_FILL;
            wr_ptr <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    wr_ptr <= wr_ptr + AW'(1);
                    if (wr_ptr == AW'(DEPTH - 1)) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    wr_ptr <= wr_ptr + AW'(1);
                    if (hit) begin
                        state     <= ST_POST;
                        trig_addr <= wr_ptr;
                        trig_idx  <= new_idx;
                        remain    <= AW'(DEPTH - 1) - new_idx;
                    end
                end
                ST_POST: begin
                    wr_ptr <= wr_ptr + AW'(1);
                    remain <= remain - AW'(1);
                    if (remain == AW'(1)) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // R7
    // A frozen window never reports capture running.
    done_not_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed);

    // R2
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (armed && !triggered && !done));

    // R5
    trig_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(state == ST_WAIT));

    // R7
    post_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (remain != '0));

    // R8
    // The base taken from the trigger address must meet the write pointer.
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_base == wr_ptr));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> ($stable(wr_ptr) && $stable(rd_base) && done));
endmodule

// File: rtl/probe_capture.sv
// Top of the probe capture core. The clock pin is the sample clock.
// Probes are compared, stored in a circular buffer and read back in
// time order, relative to the stored trigger address.
// Assumes DEPTH is a power of two and at least 8.
module probe_capture #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [1:0]         trig_pos,
    input  logic [PROBE_W-1:0] care_mask,
    input  logic [PROBE_W-1:0] match_value,
    input  logic [PROBE_W-1:0] probe_in,
    input  logic [AW-1:0]      rd_idx,
    output logic [PROBE_W-1:0] rd_data,
    output logic               armed,
    output logic               triggered,
    output logic               done
);
    logic          hit;
    logic          we;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_base;
    logic [AW-1:0] raddr;

    cap_match #(.PROBE_W(PROBE_W)) u_match (
        .sample     (probe_in),
        .care       (care_mask),
        .expect_val (match_value),
        .hit        (hit)
    );

    cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .hit       (hit),
        .pos       (trig_pos),
        .we        (we),
        .wr_ptr    (wr_ptr),
        .rd_base   (rd_base),
        .armed     (armed),
        .triggered (triggered),
        .done      (done)
    );

    // Readout index counts from the oldest retained sample.
    always_comb raddr = rd_base + rd_idx;

    cap_buffer #(.PROBE_W(PROBE_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (wr_ptr),
        .wdata (probe_in),
        .raddr (raddr),
        .rdata (rd_data)
    );

    // R3
    // While frozen, the write enable must stay off.
    no_write_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !we);
endmodule

// File: tb/probe_capture_bench.sv
`timescale 1ns/1ps
module probe_capture_bench;
    localparam int PW = 8;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [1:0] trig_pos = 2'b00;
    logic [PW-1:0] care_mask = '0, match_value = '0, probe_in = '0;
    logic [AW-1:0] rd_idx = '0;
    logic [PW-1:0] rd_data;
    logic armed, triggered, done;

    int n_checks = 0, n_fail = 0;
    bit started = 0;

    // reference model state: 0 idle, 1 capturing before trigger, 3 post, 4 done
    int m_state = 0, m_writes = 0, m_remain = 0;
    logic [PW-1:0] m_hist[$];

    always #2 clk = ~clk;

    probe_capture #(.PROBE_W(PW), .DEPTH(DEPTH)) u_probe_capture (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_pos(trig_pos),
        .care_mask(care_mask), .match_value(match_value), .probe_in(probe_in),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .armed(armed), .triggered(triggered), .done(done)
    );

    function automatic int slot_of(input logic [1:0] p);
        if (p == 2'b00) return DEPTH / 8;
        if (p == 2'b10) return DEPTH - 1 - DEPTH / 8;
        return DEPTH / 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_state = 0;
        end else if (arm) begin
            m_state = 1; m_writes = 0;
        end else if (m_state == 1 || m_state == 3) begin
            m_hist.push_back(probe_in);
            if (m_hist.size() > DEPTH) void'(m_hist.pop_front());
            if (m_state == 1) begin
                if (m_writes >= DEPTH && ((probe_in ^ match_value) & care_mask) == 0) begin
                    m_state = 3;
                    m_remain = DEPTH - 1 - slot_of(trig_pos);
                end
            end else begin
                m_remain--;
                if (m_remain == 0) m_state = 4;
            end
            m_writes++;
        end
    end

    // Flag comparison against the model on every clock (R1 R2 R7).
    always @(negedge clk) begin
        if (started) begin
            chk(armed == (m_state == 1 || m_state == 3), "R2 armed", armed, m_state);
            chk(triggered == (m_state >= 3), "R7 triggered", triggered, m_state);
            chk(done == (m_state == 4), "R7 done", done, m_state);
        end
    end

    // Sweep all indices, one per cycle, against the model history (R8).
    task automatic check_readout(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            rd_idx = AW'(i);
            #1;
            chk(m_hist.size() == DEPTH && rd_data == m_hist[i], req, rd_data,
                (m_hist.size() > i) ? int'(m_hist[i]) : -1);
        end
    endtask

    function automatic logic [PW-1:0] pattern(input int k, input int hit_a, input int hit_b,
                                              input logic [PW-1:0] hv);
        if (k == hit_a || k == hit_b) return hv;
        if (k == 25) return 8'h5D;
        return 8'h30 | PW'(k & 15);
    endfunction

    // Arm, drive the pattern, expect the trigger at write index exp_trig.
    task automatic capture(input logic [1:0] pos, input logic [PW-1:0] msk,
                           input logic [PW-1:0] val, input int hit_a, input int hit_b,
                           input logic [PW-1:0] hv, input int exp_trig, input string req);
        int k;
        int t = slot_of(pos);
        @(negedge clk);
        trig_pos = pos; care_mask = msk; match_value = val; arm = 1;
        k = 0;
        @(negedge clk);
        arm = 0;
        probe_in = pattern(0, hit_a, hit_b, hv);
        while (k < 300) begin
            @(negedge clk);
            k++;
            if (done) break;
            probe_in = pattern(k, hit_a, hit_b, hv);
        end
        // R7: done first seen one cycle after the last post-trigger write
        chk(k == exp_trig + (DEPTH - 1 - t) + 1, {req, " R7 length"}, k,
            exp_trig + (DEPTH - t));
        check_readout({req, " R8 order"});
        rd_idx = AW'(t);
        #1;
        // R6: trigger sample sits at its slot
        chk(rd_data == pattern(exp_trig, hit_a, hit_b, hv), {req, " R6 slot"}, rd_data,
            pattern(exp_trig, hit_a, hit_b, hv));
    endtask

    initial begin
        #400000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: flags after reset
        chk({armed, triggered, done} == 3'b000, "R1 reset", {armed, triggered, done}, 0);
        rst_n = 1;
        @(negedge clk);

        // R4 R5: mask zero, pre position, fires at first eligible sample
        capture(2'b00, 8'h00, 8'h00, -1, -1, 8'h00, DEPTH, "R5 pre");
        // R4 R5: early match ignored, lower nibble masked out
        capture(2'b01, 8'hF0, 8'hA0, 3, 20, 8'hA7, 20, "R4 center");
        // R4: near miss at 25 ignored, exact match at 30
        capture(2'b10, 8'hFF, 8'h5C, -1, 30, 8'h5C, 30, "R4 post");

        // R9: probe activity after freezing changes nothing
        repeat (5) begin
            @(negedge clk);
            probe_in = ~probe_in;
        end
        check_readout("R9 frozen");

        // R10: hold arm for a whole sweep; contents unchanged, no writes
        @(negedge clk);
        arm = 1;
        check_readout("R10 rearm keeps");
        // R2 R3: restart mid-capture, then code 11 acts as center
        @(negedge clk);
        arm = 0; care_mask = 8'hFF; match_value = 8'hEE;
        repeat (10) @(negedge clk);
        capture(2'b11, 8'h00, 8'h00, -1, -1, 8'h00, DEPTH, "R3 restart");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule